// File: doc/BRIEF.md
# I2C Register Slave Front End with Commit Control

This block is the serial front end of a small register bank. It watches an I2C bus through oversampled, filtered copies of SCL and SDA, recognises START, repeated START and STOP, answers a fixed 7-bit device address and turns each transaction into accesses on a plain register port: an address, write data with a one-cycle write strobe, and combinational read data. A register-address byte loads an internal address counter. Each data byte written or read advances the counter by one. A read that is not preceded by a register-address byte starts at whatever the counter holds. The usual way to read a given register is a dummy write of its address, then a repeated START and a read.

A write that has placed at least one data byte and then ends with STOP raises a one-cycle commit request, which tells the surrounding logic to copy the bank into nonvolatile storage. If the transaction ends with a repeated START instead, the request is dropped. While the storage is busy (the busy input is high), the slave leaves its own address unacknowledged. A master can therefore poll the address until the slave answers.

The controller is one state machine. ST_IDLE waits for START. ST_DEV_ADDR shifts in the address byte and moves to ST_DEV_ACK on a match when not busy, otherwise to ST_IGNORE. From ST_DEV_ACK a write goes to ST_REG_ADDR, then to ST_REG_ACK, and then alternates between ST_WR_DATA and ST_WR_ACK. From ST_DEV_ACK a read goes to ST_RD_DATA and then alternates between ST_RD_DATA and ST_RD_ACK. A master NACK in ST_RD_ACK leads to ST_IGNORE. START from any state goes to ST_DEV_ADDR, and STOP from any state goes to ST_IDLE.

Top module: `i2c_regport_slave`

## Requirements
- R1: After reset the slave does not pull SDA low, the write strobe is low and no commit pulse is given.
- R2: The slave answers the address bytes 0xA0 (write) and 0xA1 (read), which carry the 7-bit device address 0x50 in bits 7:1 and the direction in bit 0. It answers by pulling SDA low during the ninth clock of that byte.
- R3: After an address byte whose bits 7:1 are not 0x50, the slave leaves SDA released, gives no write strobe and ignores the bus until the next START.
- R4: In a write, the second byte is the register address and each later byte is data. Bytes arrive MSB first and are sampled on rising SCL. Each data byte produces exactly one write-strobe cycle carrying that byte, and the strobe starts at the falling SCL edge that begins the acknowledge bit.
- R5: A read returns the register at the address counter, MSB first, changing SDA after falling SCL. A dummy write of a register address followed by a repeated START sets the counter, and a read with no preceding address byte continues from the current counter.
- R6: The address counter advances by one after every data byte, whether written or read.
- R7: A one-cycle commit pulse follows STOP only if the transaction wrote at least one data byte since its last START. A repeated START cancels the pending request, and a transaction with no data byte gives no commit pulse.
- R8: While the busy input is high at the end of the address byte, the slave does not acknowledge its address.
- R9: A master NACK after a read byte ends the read: the slave releases SDA and drives nothing until the next START.
- R10: SCL or SDA pulses shorter than three system-clock samples are filtered out and do not count as bus edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain drive) |
| nv_busy_i | input | 1 | Nonvolatile write in progress; blocks address acknowledge |
| reg_addr_o | output | 8 | Register port address (the address counter) |
| reg_wdata_o | output | 8 | Register port write data |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_rdata_i | input | 8 | Register port read data for reg_addr_o |
| commit_o | output | 1 | One-cycle nonvolatile commit request |

## Verification
The cycle-level properties are checked on every cycle. These cover: the write strobe and commit request each last exactly one cycle; a commit follows a detected STOP; a strobe follows a detected falling SCL and is followed by a counter step; the filter output moves only after agreeing samples; and a busy input at the end of an address byte never leads into the acknowledge state. Only the bench scenarios can show the byte-level outcomes. These include whether the right register received the right value, read data ordering, the counter continuing across transactions, and a repeated START cancelling a commit. They also include a foreign address and a busy slave leaving the bank untouched, SDA staying released after a master NACK, and a short SCL spike leaving a write byte intact.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV_ADDR,
        ST_DEV_ACK,
        ST_REG_ADDR,
        ST_REG_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_IGNORE
    } slv_state_t;
endpackage

// File: rtl/i2c_rs_line_filter.sv
module i2c_rs_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_TAPS   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_TAPS-1:0]   hist_q;

    // synchroniser chain, then history of synchronised samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            hist_q <= {hist_q[FILT_TAPS-2:0], sync_q[SYNC_STAGES-1]};
            if (&hist_q)
                line_o <= 1'b1;
            else if (~|hist_q)
                line_o <= 1'b0;
        end
    end

    // R10: output only moves after the newest samples agreed
    p_filter_agree_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o != $past(line_o)) |-> ($past(hist_q[0]) == $past(hist_q[1])));
endmodule

// File: rtl/i2c_rs_bus_events.sv
module i2c_rs_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        scl_rise  = scl_f & ~scl_q;
        scl_fall  = ~scl_f & scl_q;
        bus_start = scl_f & scl_q & sda_q & ~sda_f;
        bus_stop  = scl_f & scl_q & ~sda_q & sda_f;
    end
endmodule

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave #(
    parameter logic [6:0] SLAVE_ID    = 7'h50,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_TAPS   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic       nv_busy_i,
    output logic [7:0] reg_addr_o,
    output logic [7:0] reg_wdata_o,
    output logic       reg_we_o,
    input  logic [7:0] reg_rdata_i,
    output logic       commit_o
);
    import i2c_rs_pkg::*;

    localparam int NUM_LINES = 2;
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W);
    localparam logic [BIT_CNT_W-1:0] LAST_TX  = BIT_CNT_W'(BYTE_W - 1);

    logic [NUM_LINES-1:0] line_raw, line_f;
    logic scl_rise, scl_fall, ev_start, ev_stop;

    assign line_raw = {sda_i, scl_i};

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_filt
        i2c_rs_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_TAPS  (FILT_TAPS)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(line_raw[g]),
            .line_o(line_f[g])
        );
    end

    i2c_rs_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (line_f[0]),
        .sda_f    (line_f[1]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .bus_start(ev_start),
        .bus_stop (ev_stop)
    );

    slv_state_t             state;
    logic [BIT_CNT_W-1:0]   bitcnt;
    logic [BYTE_W-1:0]      shreg;
    logic [7:0]             addr_q;
    logic [BYTE_W-1:0]      wdata_q;
    logic                   rw_q, mack_q, we_q, pend_q, commit_q;

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            rw_q     <= 1'b0;
            mack_q   <= 1'b1;
            we_q     <= 1'b0;
            pend_q   <= 1'b0;
            commit_q <= 1'b0;
        end else begin
            we_q     <= 1'b0;
            commit_q <= 1'b0;
            if (we_q)
                addr_q <= addr_q + 8'd1;
            if (ev_stop) begin
                state    <= ST_IDLE;
                commit_q <= pend_q;
                pend_q   <= 1'b0;
            end else if (ev_start) begin
                state  <= ST_DEV_ADDR;
                bitcnt <= '0;
                pend_q <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE, ST_IGNORE: ;
                    ST_DEV_ADDR: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], line_f[1]};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == LAST_BIT) begin
                            bitcnt <= '0;
                            if (shreg[7:1] == SLAVE_ID && !nv_busy_i) begin
                                state <= ST_DEV_ACK;
                                rw_q  <= shreg[0];
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (scl_fall) begin
                            if (rw_q) begin
                                state <= ST_RD_DATA;
                                shreg <= reg_rdata_i;
                            end else begin
                                state <= ST_REG_ADDR;
                            end
                        end
                    end
                    ST_REG_ADDR: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], line_f[1]};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == LAST_BIT) begin
                            bitcnt <= '0;
                            addr_q <= shreg;
                            state  <= ST_REG_ACK;
                        end
                    end
                    ST_REG_ACK, ST_WR_ACK: begin
                        if (scl_fall)
                            state <= ST_WR_DATA;
                    end
                    ST_WR_DATA: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], line_f[1]};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == LAST_BIT) begin
                            bitcnt  <= '0;
                            we_q    <= 1'b1;
                            wdata_q <= shreg;
                            pend_q  <= 1'b1;
                            state   <= ST_WR_ACK;
                        end
                    end
                    ST_RD_DATA: begin
                        if (scl_fall) begin
                            if (bitcnt == LAST_TX) begin
                                bitcnt <= '0;
                                addr_q <= addr_q + 8'd1;
                                state  <= ST_RD_ACK;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            mack_q <= line_f[1];
                        end else if (scl_fall) begin
                            if (!mack_q) begin
                                state <= ST_RD_DATA;
                                shreg <= reg_rdata_i;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        reg_addr_o  = addr_q;
        reg_wdata_o = wdata_q;
        reg_we_o    = we_q;
        commit_o    = commit_q;
        unique case (state)
            ST_DEV_ACK, ST_REG_ACK, ST_WR_ACK: sda_oe_o = 1'b1;
            ST_RD_DATA:                        sda_oe_o = ~shreg[BYTE_W-1];
            default:                           sda_oe_o = 1'b0;
        endcase
    end

    p_we_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> !reg_we_o);
    p_we_at_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> $past(scl_fall));
    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> (reg_addr_o == $past(reg_addr_o) + 8'd1));
    p_commit_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);
    p_commit_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(ev_stop));
    p_busy_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV_ADDR && nv_busy_i) |=> (state != ST_DEV_ACK));
endmodule

// File: tb/i2c_regport_slave_bench.sv
module i2c_regport_slave_bench;
    localparam int Q = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
    logic sda_oe, we, commit;
    logic [7:0] raddr, wdata, rdata;
    logic sda_bus;
    logic [7:0] bank [8];
    int checks = 0, errors = 0, we_cnt = 0, commit_cnt = 0;
    bit done = 0;

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;
    assign rdata   = bank[raddr[2:0]];

    i2c_regport_slave u_i2c_regport_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe_o(sda_oe), .nv_busy_i(busy), .reg_addr_o(raddr),
        .reg_wdata_o(wdata), .reg_we_o(we), .reg_rdata_i(rdata),
        .commit_o(commit));

    always @(posedge clk) begin
        if (we) begin
            bank[raddr[2:0]] <= wdata;
            we_cnt <= we_cnt + 1;
        end
        if (commit) commit_cnt <= commit_cnt + 1;
    end

    localparam int NV = 4;
    localparam logic [15:0] VEC [NV] = '{16'h00_3C, 16'h01_A5, 16'h02_80, 16'h05_5A};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n); repeat (n) @(negedge clk); endtask

    task automatic i2c_start;
        sda_m = 1; wq(Q); scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q);
    endtask

    task automatic i2c_stop;
        sda_m = 0; wq(Q); scl_m = 1; wq(Q); sda_m = 1; wq(2*Q);
    endtask

    task automatic wr_byte(input logic [7:0] d, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = d[i];
            if (glitch && i == 4) begin
                wq(4); scl_m = 1; wq(2); scl_m = 0; wq(Q-6);
            end else wq(Q);
            scl_m = 1; wq(2*Q); scl_m = 0; wq(Q);
        end
        sda_m = 1; wq(Q); scl_m = 1; wq(Q); ack = ~sda_bus; wq(Q); scl_m = 0; wq(Q);
    endtask

    task automatic rd_byte(input bit nack, output logic [7:0] d);
        sda_m = 1;
        for (int i = 0; i < 8; i++) begin
            wq(Q); scl_m = 1; wq(Q); d = {d[6:0], sda_bus}; wq(Q); scl_m = 0;
        end
        wq(Q); sda_m = nack; wq(Q); scl_m = 1; wq(2*Q); scl_m = 0; wq(Q); sda_m = 1;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        bit a0, a1, a2;
        logic [7:0] d, d2;
        int wc, cc;
        for (int i = 0; i < 8; i++) bank[i] = 8'h00;
        wq(5);
        // R1: reset state
        chk(sda_oe == 0 && we == 0 && commit == 0, "R1 reset", {sda_oe, we, commit}, 0);
        rst_n = 1; wq(10);
        chk(sda_oe == 0 && we == 0 && commit == 0, "R1 after release", {sda_oe, we, commit}, 0);

        // table-driven write then read-back
        for (int v = 0; v < NV; v++) begin
            wc = we_cnt; cc = commit_cnt;
            i2c_start(); wr_byte(8'hA0, 0, a0); wr_byte(VEC[v][15:8], 0, a1);
            wr_byte(VEC[v][7:0], 0, a2); i2c_stop();
            chk(a0 && a1 && a2, "R2 write acks", {a0, a1, a2}, 7);
            chk(bank[VEC[v][10:8]] == VEC[v][7:0] && we_cnt == wc + 1, "R4 write data",
                bank[VEC[v][10:8]], VEC[v][7:0]);
            chk(commit_cnt == cc + 1, "R7 commit on STOP", commit_cnt - cc, 1);
            i2c_start(); wr_byte(8'hA0, 0, a0); wr_byte(VEC[v][15:8], 0, a1);
            i2c_start(); wr_byte(8'hA1, 0, a2); rd_byte(1, d); i2c_stop();
            chk(a2, "R2 read ack", a2, 1);
            chk(d == VEC[v][7:0], "R5 read back", d, VEC[v][7:0]);
            chk(commit_cnt == cc + 1, "R7 no commit without data", commit_cnt - cc, 1);
        end

        // R6: auto increment on write and read
        i2c_start(); wr_byte(8'hA0, 0, a0); wr_byte(8'h03, 0, a1);
        wr_byte(8'h11, 0, a2); wr_byte(8'h22, 0, a2); i2c_stop();
        chk(bank[3] == 8'h11 && bank[4] == 8'h22, "R6 write increment", {bank[3], bank[4]}, 16'h1122);
        i2c_start(); wr_byte(8'hA0, 0, a0); wr_byte(8'h03, 0, a1);
        i2c_start(); wr_byte(8'hA1, 0, a2); rd_byte(0, d); rd_byte(1, d2); i2c_stop();
        chk(d == 8'h11 && d2 == 8'h22, "R6 read increment", {d, d2}, 16'h1122);
        // R5: current-address read continues at 5
        i2c_start(); wr_byte(8'hA1, 0, a2); rd_byte(1, d); i2c_stop();
        chk(d == 8'h5A, "R5 current address read", d, 8'h5A);

        // R7: repeated START cancels commit, data still written (R4)
        cc = commit_cnt;
        i2c_start(); wr_byte(8'hA0, 0, a0); wr_byte(8'h06, 0, a1); wr_byte(8'h77, 0, a2);
        i2c_start(); wr_byte(8'hA1, 0, a2); rd_byte(1, d); i2c_stop();
        chk(commit_cnt == cc, "R7 repeated START cancels", commit_cnt - cc, 0);
        chk(bank[6] == 8'h77, "R4 write before repeated START", bank[6], 8'h77);

        // R3: foreign address ignored
        wc = we_cnt; cc = commit_cnt;
        i2c_start(); wr_byte(8'hA4, 0, a0); wr_byte(8'h02, 0, a1); wr_byte(8'hFF, 0, a2); i2c_stop();
        chk(!a0 && !a1 && !a2, "R3 no ack on mismatch", {a0, a1, a2}, 0);
        chk(we_cnt == wc && bank[2] == 8'h80 && commit_cnt == cc, "R3 no write", bank[2], 8'h80);

        // R8: busy blocks address ack
        busy = 1;
        i2c_start(); wr_byte(8'hA0, 0, a0); wr_byte(8'h01, 0, a1); wr_byte(8'h00, 0, a2); i2c_stop();
        chk(!a0 && bank[1] == 8'hA5, "R8 busy nack", {a0, bank[1]}, 8'hA5);
        busy = 0;
        i2c_start(); wr_byte(8'hA0, 0, a0); i2c_stop();
        chk(a0, "R8 ack after busy", a0, 1);

        // R9: master NACK releases SDA
        i2c_start(); wr_byte(8'hA0, 0, a0); wr_byte(8'h00, 0, a1);
        i2c_start(); wr_byte(8'hA1, 0, a2); rd_byte(1, d);
        a0 = 0;
        for (int i = 0; i < 9; i++) begin
            wq(Q); scl_m = 1; wq(Q); if (!sda_bus || sda_oe) a0 = 1; wq(Q); scl_m = 0;
        end
        wq(Q); i2c_stop();
        chk(!a0, "R9 SDA released after NACK", a0, 0);

        // R10: short SCL spike ignored
        i2c_start(); wr_byte(8'hA0, 0, a0); wr_byte(8'h07, 0, a1); wr_byte(8'h3C, 1, a2); i2c_stop();
        chk(a2 && bank[7] == 8'h3C, "R10 glitch filtered", bank[7], 8'h3C);

        finish_run();
    end
endmodule